// File: doc/BRIEF.md
# AXI Response Error Interrupt Register

This block watches the write-response (B) and read-response (R) channels of an AXI master port for error responses. It keeps four error sources apart, split by channel and by error kind: slave error or decode error. When a source is detected and its record enable is set, the source's sticky status bit is set. A status bit reaches the single interrupt line only when its interrupt enable is also set.

Software reaches the block through one 32-bit register. The port is a plain write strobe with write data and a read-data bus that always shows the current values. Reads have no side effects. Software clears a status bit by writing 1 to it. The enable fields take the write data directly.

A new error is recorded in the cycle of its handshake. The interrupt output is registered, so it follows the status and the enables one clock later.

Top module: `aer_irq_reg`

## Requirements
- R1: After reset all status, record-enable and interrupt-enable bits read 0 and `irq_o` is 0.
- R2: Register layout. Bits 3:0 hold status, bits 11:8 hold record enables and bits 19:16 hold interrupt enables. Within each field the sources sit as B-slave-error at bit 3, B-decode-error at bit 2, R-slave-error at bit 1 and R-decode-error at bit 0. Bits 31:20, 15:12 and 7:4 always read 0, and writes to them have no effect.
- R3: A response code of 2'b10 counts as a slave error and 2'b11 as a decode error. Codes 2'b00 and 2'b01 count as neither. A response counts only in a cycle where valid and ready are both 1.
- R4: A detected error sets its status bit only if the record-enable bit, as held before that clock edge, is 1. Otherwise the error is not recorded.
- R5: A status bit, once set, stays set until software clears it.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If an error and a clear hit the same bit on the same edge, the bit ends up set.
- R7: Every handshaken R beat is checked, whatever its position in a burst.
- R8: `irq_o` equals the OR over the four sources of (status AND interrupt enable), as held one clock edge earlier.
- R9: A write loads both enable fields from the write data on that edge. Reading has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| b_valid | input | 1 | B channel valid |
| b_ready | input | 1 | B channel ready |
| b_resp | input | 2 | B channel response code |
| r_valid | input | 1 | R channel valid |
| r_ready | input | 1 | R channel ready |
| r_resp | input | 2 | R channel response code |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after several corner cases:
- An error and a clear on the same bit and edge. A design with the wrong priority would lose the error.
- Error codes shown with valid high and ready low. A design that ignores the handshake would record them.
- Non-error codes. A design that decodes only one response bit would flag the wrong codes.
- An error arriving while the record enable is off. A design that decides late would record it anyway.

Random traffic, with writes that also set the reserved bits, is compared every cycle against a bench model. The model checks the interrupt one clock after status and enables change, and checks that reserved bits read as zero.

// File: rtl/aer_pkg.sv
package aer_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned RESP_W  = 2;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned STAT_LSB = 0;
  localparam int unsigned REN_LSB  = 8;
  localparam int unsigned IEN_LSB  = 16;
  localparam logic [RESP_W-1:0] RESP_SLV = 2'b10;
  localparam logic [RESP_W-1:0] RESP_DEC = 2'b11;
  localparam int unsigned SRC_RD = 0;
  localparam int unsigned SRC_RS = 1;
  localparam int unsigned SRC_BD = 2;
  localparam int unsigned SRC_BS = 3;
  localparam int unsigned CH_R = 0;
  localparam int unsigned CH_B = 1;
endpackage

// File: rtl/aer_rst_sync.sv
module aer_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/aer_resp_decode.sv
module aer_resp_decode
  import aer_pkg::*;
(
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic [RESP_W-1:0] resp_i,
  output logic              slv_o,
  output logic              dec_o
);
  logic beat;

  always_comb begin
    beat  = valid_i & ready_i;
    slv_o = beat & (resp_i == RESP_SLV);
    dec_o = beat & (resp_i == RESP_DEC);
  end
endmodule

// File: rtl/aer_status_bank.sv
module aer_status_bank
  import aer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] det_i,
  input  logic               wr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] ren_o,
  output logic [NUM_SRC-1:0] ien_o
);
  logic [NUM_SRC-1:0] status_q, status_d;
  logic [NUM_SRC-1:0] ren_q, ren_d;
  logic [NUM_SRC-1:0] ien_q, ien_d;
  logic [NUM_SRC-1:0] clr;
  logic               status_en;

  always_comb begin
    clr       = wr_i ? wdata_i[STAT_LSB +: NUM_SRC] : '0;
    status_d  = (status_q & ~clr) | (det_i & ren_q);
    status_en = wr_i | (|(det_i & ren_q));
    ren_d     = wdata_i[REN_LSB +: NUM_SRC];
    ien_d     = wdata_i[IEN_LSB +: NUM_SRC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ren_q    <= '0;
      ien_q    <= '0;
    end else begin
      if (status_en) status_q <= status_d;
      if (wr_i) begin
        ren_q <= ren_d;
        ien_q <= ien_d;
      end
    end
  end

  assign status_o = status_q;
  assign ren_o    = ren_q;
  assign ien_o    = ien_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R4
    a_r4_no_record_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_q[i] && !ren_q[i]) |=> !status_q[i]);
    // R6
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (det_i[i] && ren_q[i]) |=> status_q[i]);
    // R5
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !(wr_i && wdata_i[STAT_LSB+i])) |=> status_q[i]);
  end
endmodule

// File: rtl/aer_irq_gen.sv
module aer_irq_gen
  import aer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] ien_i,
  output logic               irq_o
);
  logic irq_q, irq_d;

  always_comb irq_d = |(status_i & ien_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R8
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_i & ien_i)) |=> irq_o);
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_i & ien_i)) |=> !irq_o);
endmodule

// File: rtl/aer_irq_reg.sv
module aer_irq_reg
  import aer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              b_valid,
  input  logic              b_ready,
  input  logic [RESP_W-1:0] b_resp,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [RESP_W-1:0] r_resp,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_o
);
  logic                   rst_n_s;
  logic [NUM_CH-1:0]      ch_valid, ch_ready, ch_slv, ch_dec;
  logic [RESP_W-1:0]      ch_resp [NUM_CH];
  logic [NUM_SRC-1:0]     det, status, ren, ien;

  aer_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  always_comb begin
    ch_valid[CH_R] = r_valid;
    ch_ready[CH_R] = r_ready;
    ch_resp[CH_R]  = r_resp;
    ch_valid[CH_B] = b_valid;
    ch_ready[CH_B] = b_ready;
    ch_resp[CH_B]  = b_resp;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    aer_resp_decode i_dec (
      .valid_i(ch_valid[c]), .ready_i(ch_ready[c]), .resp_i(ch_resp[c]),
      .slv_o(ch_slv[c]), .dec_o(ch_dec[c])
    );
  end

  always_comb begin
    det         = '0;
    det[SRC_RD] = ch_dec[CH_R];
    det[SRC_RS] = ch_slv[CH_R];
    det[SRC_BD] = ch_dec[CH_B];
    det[SRC_BS] = ch_slv[CH_B];
  end

  aer_status_bank i_bank (
    .clk(clk), .rst_n(rst_n_s), .det_i(det), .wr_i(reg_wr),
    .wdata_i(reg_wdata), .status_o(status), .ren_o(ren), .ien_o(ien)
  );

  aer_irq_gen i_irq (
    .clk(clk), .rst_n(rst_n_s), .status_i(status), .ien_i(ien), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[STAT_LSB +: NUM_SRC] = status;
    reg_rdata[REN_LSB  +: NUM_SRC] = ren;
    reg_rdata[IEN_LSB  +: NUM_SRC] = ien;
  end

  // R2
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_rdata[31:20] == '0) && (reg_rdata[15:12] == '0) && (reg_rdata[7:4] == '0));
  // R3
  a_r3_no_beat_no_set: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!(r_valid && r_ready) && !(b_valid && b_ready) && !reg_wr) |=> $stable(status));
endmodule

// File: tb/test_aer_irq_reg.sv
module test_aer_irq_reg;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        b_valid, b_ready, r_valid, r_ready, reg_wr;
  logic [1:0]  b_resp, r_resp;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0] m_stat, m_ren, m_ien;
  logic       m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  aer_irq_reg i_aer_irq_reg (
    .clk(clk), .rst_n(rst_n), .b_valid(b_valid), .b_ready(b_ready),
    .b_resp(b_resp), .r_valid(r_valid), .r_ready(r_ready), .r_resp(r_resp),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic logic [3:0] detect(logic bv, logic br, logic [1:0] bc,
                                        logic rv, logic rr, logic [1:0] rc);
    logic [3:0] d;
    d[3] = bv && br && (bc == 2'b10);
    d[2] = bv && br && (bc == 2'b11);
    d[1] = rv && rr && (rc == 2'b10);
    d[0] = rv && rr && (rc == 2'b11);
    return d;
  endfunction

  function automatic logic [31:0] expect_rd(logic [3:0] s, logic [3:0] e, logic [3:0] i);
    return {12'h0, i, 4'h0, e, 4'h0, s};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    b_valid = 0; b_ready = 0; b_resp = 0;
    r_valid = 0; r_ready = 0; r_resp = 0;
    reg_wr = 0; reg_wdata = 0;
  endtask

  // one clock: model updates at the edge from pre-edge values, check at negedge
  task automatic cycle(string tag);
    logic [3:0] d, clr;
    @(posedge clk);
    d     = detect(b_valid, b_ready, b_resp, r_valid, r_ready, r_resp);
    clr   = reg_wr ? reg_wdata[3:0] : 4'h0;
    m_irq = |(m_stat & m_ien);
    m_stat = (m_stat & ~clr) | (d & m_ren);
    if (reg_wr) begin
      m_ren = reg_wdata[11:8];
      m_ien = reg_wdata[19:16];
    end
    @(negedge clk);
    check({tag, " R2 rdata"}, reg_rdata, expect_rd(m_stat, m_ren, m_ien));
    check({tag, " R8 irq"}, {31'h0, irq_o}, {31'h0, m_irq});
    idle();
  endtask

  task automatic write(logic [31:0] v);
    reg_wr = 1; reg_wdata = v;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    idle();
    m_stat = 0; m_ren = 0; m_ien = 0; m_irq = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 reset rdata", reg_rdata, 32'h0);
    check("R1 reset irq", {31'h0, irq_o}, 32'h0);
    rst_n = 1;
    repeat (3) cycle("R1 release");

    // R2: reserved bits ignore writes
    write(32'hFFFF_FFF0); cycle("R2 reserved");
    check("R2 layout", reg_rdata, 32'h000F_0F00);

    // R3: no handshake -> nothing
    b_valid = 1; b_resp = 2'b10; r_valid = 1; r_resp = 2'b11; cycle("R3 no ready");
    // R3: OKAY / EXOKAY never record
    b_valid = 1; b_ready = 1; b_resp = 2'b00; r_valid = 1; r_ready = 1; r_resp = 2'b01;
    cycle("R3 okay codes");
    check("R3 nothing set", {28'h0, reg_rdata[3:0]}, 32'h0);
    // R3: each code to its source
    b_valid = 1; b_ready = 1; b_resp = 2'b10; cycle("R3 b slv");
    check("R3 b slv bit3", {28'h0, reg_rdata[3:0]}, 32'h8);
    cycle("R8 irq after");
    check("R8 irq high", {31'h0, irq_o}, 32'h1);

    // R6: write 0 no change, write 1 clears
    write(32'h000F_0F00); cycle("R6 write0");
    check("R6 write0 keep", {28'h0, reg_rdata[3:0]}, 32'h8);
    write(32'h000F_0F08); cycle("R6 clear");
    check("R6 cleared", {28'h0, reg_rdata[3:0]}, 32'h0);
    // R6: set wins
    r_valid = 1; r_ready = 1; r_resp = 2'b11; write(32'h000F_0F01); cycle("R6 set wins");
    check("R6 set wins bit0", {28'h0, reg_rdata[3:0]}, 32'h1);

    // R7: burst, error on a middle beat only
    write(32'h000F_0F0F); cycle("R7 clr");
    r_valid = 1; r_ready = 1; r_resp = 2'b00; cycle("R7 beat0");
    r_valid = 1; r_ready = 1; r_resp = 2'b10; cycle("R7 beat1");
    r_valid = 1; r_ready = 1; r_resp = 2'b00; cycle("R7 beat2");
    check("R7 mid beat", {28'h0, reg_rdata[3:0]}, 32'h2);

    // R4: record disabled
    write(32'h000F_000F); cycle("R4 disable");
    b_valid = 1; b_ready = 1; b_resp = 2'b11; cycle("R4 b dec off");
    check("R4 not recorded", {28'h0, reg_rdata[3:0]}, 32'h0);
    // R4: enable in same write as error -> old enable applies
    b_valid = 1; b_ready = 1; b_resp = 2'b11; write(32'h000F_0400); cycle("R4 same edge");
    check("R4 old enable", {28'h0, reg_rdata[3:0]}, 32'h0);

    // R9: reads have no side effect
    b_valid = 1; b_ready = 1; b_resp = 2'b11; cycle("R9 set");
    cycle("R9 idle1"); cycle("R9 idle2");
    check("R9 stable read", reg_rdata, 32'h000F_0404);
    // R5: sticky over idle; mask interrupt
    write(32'h0000_0400); cycle("R5 mask");
    cycle("R5 masked");
    check("R5 sticky", {28'h0, reg_rdata[3:0]}, 32'h4);
    check("R8 masked irq", {31'h0, irq_o}, 32'h0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      b_valid = $urandom_range(0, 1); b_ready = $urandom_range(0, 1);
      b_resp  = 2'($urandom_range(0, 3));
      r_valid = $urandom_range(0, 1); r_ready = $urandom_range(0, 1);
      r_resp  = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) write($urandom);
      cycle("R4 R5 R6 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule